// File: doc/BRIEF.md
# Generator Clock Ratio Monitor

This block watches the dedicated clock that drives a random-number generator and decides, from the bus-clock side, whether that clock has become too slow to be trusted. Each rising edge of the generator clock flips a toggle flop in the generator domain. A two-flop synchronizer carries that toggle into the bus domain, and every change seen there counts as one generator edge. The bus side counts those edges over fixed windows of bus cycles. A window that holds too few edges means the generator clock runs below the allowed fraction of the bus clock, which by default is one sixteenth.

The result comes out on two flags. The live flag shows the verdict of the latest completed window. A neighbouring generator stalls while this flag is high and resumes when it falls. Samples that the generator produced earlier stay valid. The sticky flag latches any error until software clears it. Checking runs only while the enable input is high. The first window after enable or reset only primes the measurement and gives no verdict.

Top module: `gen_clk_monitor`

## Requirements
- R1: After reset both `clk_err_current` and `clk_err_sticky` are 0.
- R2: With the default parameters (64-cycle window, at least 4 edges required), a generator clock whose period is at most 12 bus cycles never raises `clk_err_current`, once two windows have passed since the last change of speed.
- R3: A generator clock whose period is 22 bus cycles or longer, or a generator clock that has stopped, sets `clk_err_current` to 1 within two complete windows.
- R4: `clk_err_current` changes only on the final cycle of a window, or when the block is disabled.
- R5: `clk_err_sticky` becomes 1 in the cycle after `clk_err_current` is 1.
- R6: `clk_err_sticky` stays 1 until `sticky_clr` is pulsed. It keeps that value after the clock recovers.
- R7: A `sticky_clr` pulse while `clk_err_current` is 0 makes `clk_err_sticky` 0 on the next cycle. While `clk_err_current` is 1, setting wins over clearing.
- R8: The first window after enable or reset gives no verdict. With the generator clock stopped and enable rising, `clk_err_current` is still 0 after 100 bus cycles and is 1 after 130 bus cycles.
- R9: While `enable` is 0, `clk_err_current` is 0 from the next cycle onward, and `clk_err_sticky` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, shared by both domains |
| gen_clk | input | 1 | Generator clock, asynchronous to `clk` |
| enable | input | 1 | Monitoring enable |
| sticky_clr | input | 1 | Single-cycle clear of the sticky flag |
| clk_err_current | output | 1 | Verdict of the last completed window: 1 means too slow |
| clk_err_sticky | output | 1 | Latched clock error |

## Verification
The bench builds the block with its default 64-cycle window and 4-edge threshold. With these values a whole verdict takes about 130 bus cycles, so many speed changes fit into a short run. The bench draws random generator periods from a band that is clearly fast enough and a band that is clearly too slow. It leaves out the periods near the threshold, where a window's edge count depends on phase. It also steps directly through the priming window, the clear-versus-set conflict, recovery of the clock and disabling.

// File: rtl/gen_clk_monitor.sv
module gen_clk_monitor #(
  parameter int WINDOW    = 64,
  parameter int MIN_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_clk,
  input  logic enable,
  input  logic sticky_clr,
  output logic clk_err_current,
  output logic clk_err_sticky
);
  localparam int WW = $clog2(WINDOW);
  localparam int EW = $clog2(MIN_EDGES + 1);

  logic          gen_tog;
  logic [2:0]    sync_q;
  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt, edge_nxt;
  logic          primed;
  logic          edge_seen, win_end, too_slow;

  always_ff @(posedge gen_clk or negedge rst_n)
    if (!rst_n) gen_tog <= 1'b0;
    else        gen_tog <= ~gen_tog;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], gen_tog};

  assign edge_seen = sync_q[2] ^ sync_q[1];
  assign win_end   = enable && (win_cnt == WW'(WINDOW - 1));
  assign edge_nxt  = (edge_seen && edge_cnt != EW'(MIN_EDGES)) ? edge_cnt + 1'b1 : edge_cnt;
  assign too_slow  = edge_nxt < EW'(MIN_EDGES);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win_cnt         <= '0;
      edge_cnt        <= '0;
      primed          <= 1'b0;
      clk_err_current <= 1'b0;
    end else if (!enable) begin
      win_cnt         <= '0;
      edge_cnt        <= '0;
      primed          <= 1'b0;
      clk_err_current <= 1'b0;
    end else if (win_end) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      primed   <= 1'b1;
      if (primed) clk_err_current <= too_slow;
    end else begin
      win_cnt  <= win_cnt + 1'b1;
      edge_cnt <= edge_nxt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               clk_err_sticky <= 1'b0;
    else if (clk_err_current) clk_err_sticky <= 1'b1;
    else if (sticky_clr)      clk_err_sticky <= 1'b0;
endmodule

module gen_clk_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sticky_clr,
  input logic clk_err_current,
  input logic clk_err_sticky,
  input logic win_end,
  input logic primed
);
  a_r5_sticky_follows: assert property (@(posedge clk) disable iff (!rst_n)
    clk_err_current |=> clk_err_sticky);
  a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_err_sticky && !sticky_clr) |=> clk_err_sticky);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr && !clk_err_current) |=> !clk_err_sticky);
  a_r9_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !clk_err_current);
  a_r4_update_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(clk_err_current) && $past(enable)) |-> $past(win_end));
  a_r8_needs_priming: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_err_current) |-> $past(primed));
endmodule

bind gen_clk_monitor gen_clk_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sticky_clr(sticky_clr),
  .clk_err_current(clk_err_current), .clk_err_sticky(clk_err_sticky),
  .win_end(win_end), .primed(primed));

// File: tb/sim_gen_clk_monitor.sv
`timescale 1ns/1ps
module sim_gen_clk_monitor;
  logic clk = 0, rst_n = 0, gen_clk = 0, enable = 0, sticky_clr = 0;
  logic clk_err_current, clk_err_sticky;
  int vectors = 0, miscompares = 0;
  int gen_half = 0, gen_cnt = 0;
  bit done = 0;

  gen_clk_monitor u0 (.clk(clk), .rst_n(rst_n), .gen_clk(gen_clk), .enable(enable),
    .sticky_clr(sticky_clr), .clk_err_current(clk_err_current), .clk_err_sticky(clk_err_sticky));

  always #2 clk = ~clk;

  always @(negedge clk)
    if (gen_half > 0) begin
      gen_cnt++;
      if (gen_cnt >= gen_half) begin gen_cnt = 0; gen_clk = ~gen_clk; end
    end

  function automatic bit expect_err(int half);
    return (half == 0) || (2 * half >= 22);
  endfunction

  task automatic check(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    cyc(3);
    check("R1 live", clk_err_current, 0);
    check("R1 sticky", clk_err_sticky, 0);
    rst_n = 1;
    cyc(2);
    // R8: stopped clock, priming window gives no verdict
    enable = 1;
    cyc(100);
    check("R8 no verdict in first window", clk_err_current, 0);
    cyc(30);
    check("R8 R3 verdict after second window", clk_err_current, 1);
    cyc(1);
    check("R5 sticky set", clk_err_sticky, 1);
    // R7: set wins while error live
    sticky_clr = 1; cyc(1); sticky_clr = 0;
    check("R7 set wins over clear", clk_err_sticky, 1);
    // recovery
    gen_half = 2;
    cyc(200);
    check("R2 recovered", clk_err_current, 0);
    check("R6 sticky kept after recovery", clk_err_sticky, 1);
    sticky_clr = 1; cyc(1); sticky_clr = 0;
    check("R7 clear", clk_err_sticky, 0);
    // random speeds
    for (int i = 0; i < 12; i++) begin
      int h;
      if ($urandom_range(1, 0) == 1) h = $urandom_range(6, 1);
      else h = ($urandom_range(4, 0) == 0) ? 0 : $urandom_range(20, 11);
      gen_half = h;
      cyc(200);
      check(expect_err(h) ? "R3 slow" : "R2 fast", clk_err_current, expect_err(h));
      cyc(1);
      if (expect_err(h)) check("R5 sticky", clk_err_sticky, 1);
      sticky_clr = 1; cyc(2); sticky_clr = 0;
      check("R7 clear outcome", clk_err_sticky, expect_err(h));
    end
    // R9: disable while error
    gen_half = 0;
    cyc(200);
    check("R3 stopped", clk_err_current, 1);
    enable = 0;
    cyc(1);
    check("R9 live low when disabled", clk_err_current, 0);
    check("R9 sticky kept", clk_err_sticky, 1);
    cyc(150);
    check("R9 stays low", clk_err_current, 0);
    // R4: re-enable with stopped clock; verdict only at window ends
    enable = 1;
    cyc(64);
    check("R4 R8 no change mid priming", clk_err_current, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule